// File: doc/BRIEF.md
# ATAPI Device Packet-Command Engine

This block is the device half of an ATA/ATAPI register interface. It holds the task-file registers that a host touches over a plain register read/write port: status, error, feature, interrupt reason, the two byte-count bytes, device control and command. A PACKET command opens a reception phase in which the host writes a 12-byte command packet as six 16-bit words through the data port. The engine then hands the packet to a command decoder on a valid/ready stream and waits for the decoder's response descriptor.

A response either completes at once (zero length), streams by PIO in blocks, or streams by DMA bursts. PIO words come from a local buffer RAM through an asynchronous word-address read port. Once per block and at the end of the data, the engine raises its interrupt. DMA bursts are requested on a separate valid/ready port and each one is granted a byte count. The pending interrupt is a single flag. Reading status clears it, but only when BSY is clear. Any command write clears it. A mask bit in device control gates the output pin and leaves the flag itself intact.

Back-pressure rules: `pkt_valid` stays high with `pkt_data` stable until the decoder takes it with `pkt_ready`. `rsp_ready` is high only while the engine waits with no packet outstanding. `dma_req_ready` is high only in the DMA phase. A command write in the same cycle lowers both `rsp_ready` and `dma_req_ready`.

Top module: `atapi_dev_engine`

Register addresses (`reg_addr`): 0 data, 1 error (read) / feature (write), 2 interrupt reason, 3 byte-count low, 4 byte-count high, 5 status (read, side effect) / command (write), 6 status with no side effect (read) / device control (write). Status values: 0x58 = DRDY|DSC|DRQ, 0xD0 = BSY|DRDY|DSC, 0x50 = DRDY|DSC, 0x51 = DRDY|DSC|CHK. Reason codes: 1 = command packet expected, 2 = data to host, 3 = complete.

## Requirements
- R1: After reset, status, error and interrupt reason read 0, `intrq` is low and `pkt_valid` is low.
- R2: Writing command 0xA0 clears the pending interrupt. It sets status to 0x58 and interrupt reason to 1, and it copies feature bits [1:0] into error bits [1:0] (bit 0 selects DMA for the response).
- R3: During reception, status stays 0x58 after each of the first five data-port writes. The sixth write sets status to 0xD0 and raises `pkt_valid`, with word k at `pkt_data[16k+15:16k]`. `pkt_valid` and `pkt_data` hold until `pkt_ready`.
- R4: A non-zero PIO response loads the byte-count bytes with `rsp_blk` (low at address 3, high at address 4). It sets status 0x58 and reason 2 and raises the interrupt.
- R5: Each PIO data-port read returns the buffer word at word address offset/2, starting at 0, and advances the offset by 2 bytes. When the bytes read reach a multiple of the block size before the end, the interrupt is raised.
- R6: The read that reaches the response length sets status 0x50 and reason 3 and raises the interrupt. Data-port reads outside the PIO phase return 0 and change neither status nor the interrupt.
- R7: A DMA response sets status 0xD0 and reason 2 and raises no interrupt. Each burst is granted the smaller of the requested and remaining bytes. The final burst sets status 0x50 and raises the interrupt, and `dma_done` is high for exactly the one cycle after it.
- R8: A side-effect status read (address 5) clears the pending interrupt when BSY is clear. A read at address 6 never clears it. A raise in the same cycle as a clear leaves it pending.
- R9: Device control bit 1 set forces `intrq` low while the flag stays pending. Clearing the bit drives `intrq` high again if the flag is still pending.
- R10: Command 0x00 aborts from any phase: the engine goes idle, status becomes 0x51, the interrupt is raised, and later data-port reads return 0.
- R11: A zero-length response completes at once with status 0x50, reason 3 and an interrupt.
- R12: A command write in the same cycle as a DMA burst request holds the burst off (`dma_req_ready` low). The burst is then granted on the next cycle with the offset unchanged.
- R13: Any other command value only clears the pending interrupt and leaves status and phase unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| intrq | output | 1 | Interrupt request to host |
| pkt_valid | output | 1 | Command packet available |
| pkt_ready | input | 1 | Decoder accepts packet |
| pkt_data | output | PKT_BYTES*8 | Received command packet |
| rsp_valid | input | 1 | Response descriptor valid |
| rsp_ready | output | 1 | Engine accepts descriptor |
| rsp_len | input | LEN_W | Response length in bytes |
| rsp_blk | input | 16 | PIO block size in bytes |
| buf_addr | output | LEN_W-1 | Buffer RAM word address |
| buf_rdata | input | 16 | Buffer RAM read word |
| dma_req_valid | input | 1 | DMA burst request |
| dma_req_ready | output | 1 | Burst accepted |
| dma_req_len | input | LEN_W | Requested burst bytes |
| dma_grant_len | output | LEN_W | Granted burst bytes |
| dma_off | output | LEN_W | Byte offset of the burst |
| dma_done | output | 1 | One-cycle end-of-DMA event |

## Verification
Two things can happen in the same cycle. A host command write arrives on the register port while the DMA port presents a burst request. The command must win and the burst must wait one cycle. The bench provokes this by driving both in one cycle during a DMA response and checking that `dma_req_ready` is low there. It then checks that the next cycle grants the requested bytes at the unchanged offset and that the transfer still ends on the right byte count. A sweep over many response lengths and block sizes checks each PIO word and each interrupt against a boundary count worked out in the bench.

// File: rtl/atapi_eng_pkg.sv
package atapi_eng_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD_RX, ST_WAIT, ST_PIO_OUT, ST_DMA_OUT
  } eng_state_e;

  localparam logic [2:0] A_DATA    = 3'd0;
  localparam logic [2:0] A_ERRFEAT = 3'd1;
  localparam logic [2:0] A_REASON  = 3'd2;
  localparam logic [2:0] A_BCLO    = 3'd3;
  localparam logic [2:0] A_BCHI    = 3'd4;
  localparam logic [2:0] A_STATCMD = 3'd5;
  localparam logic [2:0] A_ALTCTL  = 3'd6;

  localparam logic [7:0] STAT_XFER  = 8'h58;
  localparam logic [7:0] STAT_BUSY  = 8'hD0;
  localparam logic [7:0] STAT_DONE  = 8'h50;
  localparam logic [7:0] STAT_ABORT = 8'h51;
  localparam logic [7:0] STAT_BSY   = 8'h80;
  localparam logic [7:0] STAT_DRQ   = 8'h08;

  localparam logic [7:0] CMD_PACKET = 8'hA0;
  localparam logic [7:0] CMD_NOP    = 8'h00;

  localparam logic [1:0] RSN_CMD = 2'd1;
  localparam logic [1:0] RSN_IN  = 2'd2;
  localparam logic [1:0] RSN_END = 2'd3;
endpackage

// File: rtl/atapi_irq_ctl.sv
module atapi_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic raise,
  input  logic clear,
  input  logic nien,
  output logic pending,
  output logic intrq
);
  always_ff @(posedge clk) begin
    if (!rst_n)     pending <= 1'b0;
    else if (raise) pending <= 1'b1;
    else if (clear) pending <= 1'b0;
  end

  assign intrq = pending & ~nien;

  // raise outranks a clear in the same cycle
  p_raise_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    raise |=> pending);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !clear) |=> pending);
  p_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !raise) |=> !pending);
endmodule

// File: rtl/atapi_pkt_rx.sv
module atapi_pkt_rx #(
  parameter int PKT_WORDS = 6,
  localparam int IDX_W = $clog2(PKT_WORDS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [15:0]             wr_word,
  input  logic                    hand,
  input  logic                    abort,
  input  logic                    ready,
  output logic                    valid,
  output logic [PKT_WORDS*16-1:0] data
);
  for (genvar i = 0; i < PKT_WORDS; i++) begin : g_word
    logic [15:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                    word_q <= '0;
      else if (wr_en && wr_idx == IDX_W'(i))         word_q <= wr_word;
    end
    assign data[16*i +: 16] = word_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              valid <= 1'b0;
    else if (hand)           valid <= 1'b1;
    else if (abort || ready) valid <= 1'b0;
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !abort) |=> (valid && $stable(data)));
endmodule

// File: rtl/atapi_dev_engine.sv
module atapi_dev_engine
  import atapi_eng_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int PKT_BYTES = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2:0]             reg_addr,
  input  logic                   reg_wr,
  input  logic                   reg_rd,
  input  logic [15:0]            reg_wdata,
  output logic [15:0]            reg_rdata,
  output logic                   intrq,
  output logic                   pkt_valid,
  input  logic                   pkt_ready,
  output logic [PKT_BYTES*8-1:0] pkt_data,
  input  logic                   rsp_valid,
  output logic                   rsp_ready,
  input  logic [LEN_W-1:0]       rsp_len,
  input  logic [15:0]            rsp_blk,
  output logic [LEN_W-2:0]       buf_addr,
  input  logic [15:0]            buf_rdata,
  input  logic                   dma_req_valid,
  output logic                   dma_req_ready,
  input  logic [LEN_W-1:0]       dma_req_len,
  output logic [LEN_W-1:0]       dma_grant_len,
  output logic [LEN_W-1:0]       dma_off,
  output logic                   dma_done
);
  localparam int PKT_WORDS = PKT_BYTES / 2;
  localparam int IDX_W     = $clog2(PKT_WORDS);

  eng_state_e       state;
  logic [7:0]       status;
  logic [1:0]       err_r, feat_r, reason;
  logic [15:0]      bcnt, blk_len, blk_left;
  logic             nien;
  logic [LEN_W-1:0] off, len;
  logic             irq_pending;

  // host strobes
  logic wr_cmd, wr_data, rd_stat, pio_rd, rx_wr, rsp_fire, dma_fire;
  logic is_nop, is_packet;
  assign wr_cmd    = reg_wr && (reg_addr == A_STATCMD);
  assign wr_data   = reg_wr && (reg_addr == A_DATA);
  assign rd_stat   = reg_rd && (reg_addr == A_STATCMD);
  assign pio_rd    = reg_rd && (reg_addr == A_DATA) && (state == ST_PIO_OUT);
  assign rx_wr     = wr_data && (state == ST_CMD_RX);
  assign is_nop    = reg_wdata[7:0] == CMD_NOP;
  assign is_packet = reg_wdata[7:0] == CMD_PACKET;

  assign rsp_ready     = (state == ST_WAIT) && !pkt_valid && !wr_cmd;
  assign dma_req_ready = (state == ST_DMA_OUT) && !wr_cmd;
  assign rsp_fire      = rsp_valid && rsp_ready;
  assign dma_fire      = dma_req_valid && dma_req_ready;

  // offset arithmetic
  logic [LEN_W-1:0] off_nx2, remain;
  logic rx_last, pio_last, blk_edge, dma_last;
  assign off_nx2       = off + LEN_W'(2);
  assign remain        = len - off;
  assign rx_last       = off_nx2 >= LEN_W'(PKT_BYTES);
  assign pio_last      = off_nx2 >= len;
  assign blk_edge      = blk_left <= 16'd2;
  assign dma_grant_len = (dma_req_len < remain) ? dma_req_len : remain;
  assign dma_last      = dma_grant_len == remain;
  assign buf_addr      = off[LEN_W-1:1];
  assign dma_off       = off;

  // interrupt sources
  logic raise, clear;
  assign raise = (wr_cmd && is_nop)
              || (rsp_fire && ((rsp_len == '0) || !err_r[0]))
              || (pio_rd && (pio_last || blk_edge))
              || (dma_fire && dma_last);
  assign clear = wr_cmd || (rd_stat && !status[7]);

  atapi_irq_ctl u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .raise  (raise),
    .clear  (clear),
    .nien   (nien),
    .pending(irq_pending),
    .intrq  (intrq)
  );

  atapi_pkt_rx #(.PKT_WORDS(PKT_WORDS)) u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (rx_wr),
    .wr_idx (off[IDX_W:1]),
    .wr_word(reg_wdata),
    .hand   (rx_wr && rx_last),
    .abort  (wr_cmd),
    .ready  (pkt_ready),
    .valid  (pkt_valid),
    .data   (pkt_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      status   <= 8'h00;
      err_r    <= '0;
      feat_r   <= '0;
      reason   <= '0;
      bcnt     <= '0;
      nien     <= 1'b0;
      off      <= '0;
      len      <= '0;
      blk_len  <= '0;
      blk_left <= '0;
      dma_done <= 1'b0;
    end else begin
      dma_done <= dma_fire && dma_last;
      if (reg_wr) begin
        case (reg_addr)
          A_ERRFEAT: feat_r      <= reg_wdata[1:0];
          A_BCLO:    bcnt[7:0]   <= reg_wdata[7:0];
          A_BCHI:    bcnt[15:8]  <= reg_wdata[7:0];
          A_ALTCTL:  nien        <= reg_wdata[1];
          default: ;
        endcase
      end
      if (wr_cmd) begin
        if (is_packet) begin
          state  <= ST_CMD_RX;
          status <= STAT_XFER;
          err_r  <= feat_r;
          reason <= RSN_CMD;
          off    <= '0;
          len    <= LEN_W'(PKT_BYTES);
        end else if (is_nop) begin
          state  <= ST_IDLE;
          status <= STAT_ABORT;
          off    <= '0;
        end
      end else begin
        if (rx_wr) begin
          if (rx_last) begin
            state  <= ST_WAIT;
            status <= (status & ~STAT_DRQ) | STAT_BSY;
            off    <= '0;
          end else begin
            off <= off_nx2;
          end
        end
        if (rsp_fire) begin
          off <= '0;
          len <= rsp_len;
          if (rsp_len == '0) begin
            state  <= ST_IDLE;
            status <= STAT_DONE;
            reason <= RSN_END;
          end else if (err_r[0]) begin
            state  <= ST_DMA_OUT;
            status <= STAT_BUSY;
            reason <= RSN_IN;
          end else begin
            state    <= ST_PIO_OUT;
            status   <= STAT_XFER;
            reason   <= RSN_IN;
            bcnt     <= rsp_blk;
            blk_len  <= rsp_blk;
            blk_left <= rsp_blk;
          end
        end
        if (pio_rd) begin
          if (pio_last) begin
            state  <= ST_IDLE;
            status <= status & ~STAT_DRQ;
            reason <= RSN_END;
            off    <= '0;
          end else begin
            off      <= off_nx2;
            blk_left <= blk_edge ? blk_len : blk_left - 16'd2;
          end
        end
        if (dma_fire) begin
          if (dma_last) begin
            state  <= ST_IDLE;
            status <= STAT_DONE;
            off    <= '0;
          end else begin
            off <= off + dma_grant_len;
          end
        end
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_DATA:    reg_rdata = (state == ST_PIO_OUT) ? buf_rdata : 16'h0000;
      A_ERRFEAT: reg_rdata = {14'b0, err_r};
      A_REASON:  reg_rdata = {14'b0, reason};
      A_BCLO:    reg_rdata = {8'b0, bcnt[7:0]};
      A_BCHI:    reg_rdata = {8'b0, bcnt[15:8]};
      A_STATCMD,
      A_ALTCTL:  reg_rdata = {8'b0, status};
      default:   reg_rdata = 16'h0000;
    endcase
  end

  p_pio_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PIO_OUT) |-> (status == STAT_XFER));
  p_busy_nodrq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    status[7] |-> !status[3]);
  p_dma_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done |-> (status == STAT_DONE && irq_pending && state == ST_IDLE));
  p_nop_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && is_nop) |=> (state == ST_IDLE && status == STAT_ABORT && irq_pending));
  p_cmd_vs_dma_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !is_nop && !is_packet && state == ST_DMA_OUT) |=> (state == ST_DMA_OUT && $stable(off)));
endmodule

// File: tb/atapi_dev_engine_tb.sv
module atapi_dev_engine_tb;
  localparam int LEN_W = 16;
  localparam int PKT_BYTES = 12;
  localparam logic [2:0] AD_DATA = 3'd0, AD_ERR = 3'd1, AD_RSN = 3'd2, AD_BLO = 3'd3,
                         AD_BHI = 3'd4, AD_STAT = 3'd5, AD_ALT = 3'd6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic intrq, pkt_valid, rsp_ready, dma_req_ready, dma_done;
  logic pkt_ready = 1'b0, rsp_valid = 1'b0, dma_req_valid = 1'b0;
  logic [PKT_BYTES*8-1:0] pkt_data;
  logic [LEN_W-1:0] rsp_len = '0, dma_req_len = '0, dma_grant_len, dma_off;
  logic [15:0] rsp_blk = '0;
  logic [LEN_W-2:0] buf_addr;
  logic [15:0] buf_rdata;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  function automatic logic [15:0] wexp(int a);
    return 16'((a * 259 + 90) & 16'hFFFF);
  endfunction
  function automatic logic [15:0] pw(int k);
    return 16'(16'hC000 + k * 16'h0111);
  endfunction

  assign buf_rdata = wexp(int'(buf_addr));

  atapi_dev_engine #(.LEN_W(LEN_W), .PKT_BYTES(PKT_BYTES)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .intrq(intrq),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_data(pkt_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_len(rsp_len), .rsp_blk(rsp_blk),
    .buf_addr(buf_addr), .buf_rdata(buf_rdata),
    .dma_req_valid(dma_req_valid), .dma_req_ready(dma_req_ready), .dma_req_len(dma_req_len),
    .dma_grant_len(dma_grant_len), .dma_off(dma_off), .dma_done(dma_done)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic hw(logic [2:0] a, logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask
  task automatic hr(logic [2:0] a, output logic [15:0] v);
    reg_rd = 1'b1; reg_addr = a;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask
  task automatic peek(logic [2:0] a, output logic [15:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask
  task automatic send_packet();
    hw(AD_STAT, 16'h00A0);
    for (int k = 0; k < 6; k++) hw(AD_DATA, pw(k));
  endtask
  task automatic take_packet();
    pkt_ready = 1'b1;
    @(negedge clk);
    pkt_ready = 1'b0;
  endtask
  task automatic start_rsp(int ln, int bk);
    rsp_valid = 1'b1; rsp_len = LEN_W'(ln); rsp_blk = 16'(bk);
    #1 chk("R4 rsp_ready", 32'(rsp_ready), 32'd1);
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    peek(AD_STAT, v); chk("R1 status", 32'(v), 32'h00);
    peek(AD_ERR, v);  chk("R1 error", 32'(v), 32'h00);
    peek(AD_RSN, v);  chk("R1 reason", 32'(v), 32'h00);
    chk("R1 intrq", 32'(intrq), 0);
    chk("R1 pkt_valid", 32'(pkt_valid), 0);

    // R2 packet start, R3 reception
    hw(AD_ERR, 16'h0002);
    hw(AD_STAT, 16'h00A0);
    peek(AD_STAT, v); chk("R2 status", 32'(v), 32'h58);
    peek(AD_RSN, v);  chk("R2 reason", 32'(v), 32'h01);
    peek(AD_ERR, v);  chk("R2 error copy", 32'(v), 32'h02);
    chk("R2 intrq", 32'(intrq), 0);
    for (int k = 0; k < 5; k++) begin
      hw(AD_DATA, pw(k));
      peek(AD_STAT, v); chk("R3 status mid", 32'(v), 32'h58);
      chk("R3 no valid yet", 32'(pkt_valid), 0);
    end
    hw(AD_DATA, pw(5));
    peek(AD_STAT, v); chk("R3 status busy", 32'(v), 32'hD0);
    chk("R3 pkt_valid", 32'(pkt_valid), 1);
    for (int k = 0; k < 6; k++) chk("R3 word", 32'(pkt_data[16*k +: 16]), 32'(pw(k)));
    chk("R3 rsp held off", 32'(rsp_ready), 0);
    repeat (3) @(negedge clk);
    chk("R3 valid held", 32'(pkt_valid), 1);
    chk("R3 data held", 32'(pkt_data[15:0]), 32'(pw(0)));
    take_packet();
    chk("R3 valid dropped", 32'(pkt_valid), 0);

    // R4 PIO start
    start_rsp(20, 8);
    peek(AD_BLO, v);  chk("R4 bcnt lo", 32'(v), 32'h08);
    peek(AD_BHI, v);  chk("R4 bcnt hi", 32'(v), 32'h00);
    peek(AD_STAT, v); chk("R4 status", 32'(v), 32'h58);
    peek(AD_RSN, v);  chk("R4 reason", 32'(v), 32'h02);
    chk("R4 intrq", 32'(intrq), 1);
    // R8 read at address 6 keeps it, status read clears
    hr(AD_ALT, v);
    chk("R8 alt keeps", 32'(intrq), 1);
    hr(AD_STAT, v);
    chk("R8 status value", 32'(v), 32'h58);
    chk("R8 status clears", 32'(intrq), 0);

    // R5 PIO data and block interrupts
    for (int i = 0; i < 10; i++) begin
      int b;
      hr(AD_DATA, v);
      chk("R5 data word", 32'(v), 32'(wexp(i)));
      b = 2 * (i + 1);
      chk("R5 block irq", 32'(intrq), 32'((b % 8 == 0) || b == 20));
      if (i < 9 && intrq) hr(AD_STAT, v);
    end
    // R6 end of data
    peek(AD_STAT, v); chk("R6 status", 32'(v), 32'h50);
    peek(AD_RSN, v);  chk("R6 reason", 32'(v), 32'h03);
    hr(AD_DATA, v);   chk("R6 idle read", 32'(v), 32'h0000);
    peek(AD_STAT, v); chk("R6 status unchanged", 32'(v), 32'h50);
    chk("R6 intrq kept", 32'(intrq), 1);

    // R9 mask
    hw(AD_ALT, 16'h0002);
    chk("R9 masked", 32'(intrq), 0);
    hw(AD_ALT, 16'h0000);
    chk("R9 unmasked", 32'(intrq), 1);
    hr(AD_STAT, v);
    chk("R8 cleared", 32'(intrq), 0);

    // R10 abort from idle, R13 other command
    hw(AD_STAT, 16'h0000);
    peek(AD_STAT, v); chk("R10 status", 32'(v), 32'h51);
    chk("R10 intrq", 32'(intrq), 1);
    hw(AD_STAT, 16'h00EF);
    peek(AD_STAT, v); chk("R13 status kept", 32'(v), 32'h51);
    chk("R13 cleared", 32'(intrq), 0);

    // R7 DMA and R12 collision
    hw(AD_ERR, 16'h0001);
    send_packet();
    peek(AD_ERR, v); chk("R2 dma copy", 32'(v), 32'h01);
    take_packet();
    start_rsp(10, 16'h0800);
    peek(AD_STAT, v); chk("R7 status", 32'(v), 32'hD0);
    peek(AD_RSN, v);  chk("R7 reason", 32'(v), 32'h02);
    chk("R7 no irq", 32'(intrq), 0);
    dma_req_valid = 1'b1; dma_req_len = 16'd4;
    #1 chk("R7 ready", 32'(dma_req_ready), 1);
    chk("R7 grant", 32'(dma_grant_len), 4);
    chk("R7 off", 32'(dma_off), 0);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AD_STAT; reg_wdata = 16'h00EF;
    #1 chk("R12 held off", 32'(dma_req_ready), 0);
    @(negedge clk);
    reg_wr = 1'b0;
    #1 chk("R12 ready next", 32'(dma_req_ready), 1);
    chk("R12 grant", 32'(dma_grant_len), 4);
    chk("R12 off", 32'(dma_off), 4);
    @(negedge clk);
    dma_req_len = 16'd8;
    #1 chk("R7 clip grant", 32'(dma_grant_len), 2);
    @(negedge clk);
    dma_req_valid = 1'b0;
    chk("R7 done pulse", 32'(dma_done), 1);
    peek(AD_STAT, v); chk("R7 status end", 32'(v), 32'h50);
    chk("R7 irq end", 32'(intrq), 1);
    @(negedge clk);
    chk("R7 done one cycle", 32'(dma_done), 0);
    hr(AD_STAT, v);

    // R11 zero length
    hw(AD_ERR, 16'h0000);
    send_packet(); take_packet();
    start_rsp(0, 8);
    peek(AD_STAT, v); chk("R11 status", 32'(v), 32'h50);
    peek(AD_RSN, v);  chk("R11 reason", 32'(v), 32'h03);
    chk("R11 irq", 32'(intrq), 1);
    hr(AD_STAT, v);

    // R10 abort mid PIO
    send_packet(); take_packet();
    start_rsp(8, 4);
    hr(AD_STAT, v);
    hr(AD_DATA, v); chk("R5 first word", 32'(v), 32'(wexp(0)));
    hw(AD_STAT, 16'h0000);
    peek(AD_STAT, v); chk("R10 abort status", 32'(v), 32'h51);
    chk("R10 abort irq", 32'(intrq), 1);
    hr(AD_DATA, v); chk("R10 read after abort", 32'(v), 32'h0000);

    // R5/R6 sweep of lengths and block sizes
    for (int ln = 2; ln <= 16; ln += 2) begin
      for (int bk = 2; bk <= 8; bk += 2) begin
        send_packet(); take_packet();
        start_rsp(ln, bk);
        chk("R4 sweep irq", 32'(intrq), 1);
        hr(AD_STAT, v);
        for (int i = 0; i < ln / 2; i++) begin
          int b;
          hr(AD_DATA, v);
          chk("R5 sweep word", 32'(v), 32'(wexp(i)));
          b = 2 * (i + 1);
          chk("R5 sweep irq", 32'(intrq), 32'((b % bk == 0) || b == ln));
          if (intrq) hr(AD_STAT, v);
        end
        peek(AD_RSN, v); chk("R6 sweep reason", 32'(v), 32'h03);
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule